// File: doc/BRIEF.md
# Data-Space Address Decoder with External Wait States

This block sits between a small processor core and its data memories. Each core request carries a 16-bit data-space address. The block sorts that address into one of four regions. Three of them are internal: the working registers, the I/O register window and on-chip SRAM. For these it raises one target select and gives the offset inside that region. Every address above on-chip SRAM belongs to an external SRAM port. The block reaches that port over a multiplexed address/data bus with active-low read and write strobes.

The core request is a valid/ready stream. The block lowers `req_ready` while an external access is in progress. While `req_valid` is high and `req_ready` is low, the core must keep the address, direction and write data unchanged. A request is accepted on the rising edge where both are high. Internal requests are accepted in the cycle they are presented. An external request is held back for one cycle plus the number of wait states selected by `cfg_ws`. During that time `stall` is high. External reads return their byte on `rsp_data`, with a one-cycle `rsp_valid` pulse in the cycle after acceptance. The external port is used only while `cfg_ext_en` is set. With the port disabled, an external-region access completes at once, drives no strobe, and a read returns zero.

Top module: `dspace_dec`

## Requirements
- R1: With `req_valid` high, addresses 0..31 assert `sel_gpr` only, and `tgt_off` equals the address.
- R2: With `req_valid` high, addresses 32..95 assert `sel_io` only, and `tgt_off` equals the address minus 32.
- R3: With `req_valid` high, addresses 96..607 assert `sel_sram` only, and `tgt_off` equals the address minus 96.
- R4: An internal access (address below 608) is accepted in its first cycle with `stall` low. Both `ext_rd_n` and `ext_wr_n` stay high (inactive) throughout.
- R5: With `cfg_ext_en`=1 and `cfg_ws`=0, an access to addresses 608..65535 holds `stall` high (and `req_ready` low) for exactly 1 cycle, then accepts. No internal select is raised.
- R6: With `cfg_ws` = 1, 2 or 3, the external stall lasts 2, 3 or 4 cycles. The strobe that matches the direction (`ext_rd_n` for reads, `ext_wr_n` for writes) is low for `cfg_ws`+1 cycles. The other strobe stays high.
- R7: In the first cycle of an external access, `ext_ale` is 1, `ext_ad_out` carries address bits 7:0, `ext_ad_oe` is 1 and `ext_addr_hi` carries address bits 15:8. In the strobe cycles of a write, `ext_ad_out` carries the write data with `ext_ad_oe`=1. In the strobe cycles of a read, `ext_ad_oe` is 0.
- R8: An external read samples `ext_ad_in` on the last strobe cycle. `rsp_valid` is 1 for exactly the following cycle, with that byte on `rsp_data`.
- R9: With `cfg_ext_en`=0, an access above 607 is accepted at once with no stall and no strobe, and a write there changes no external byte. A read there gives `rsp_valid`=1 with `rsp_data`=0x00 in the following cycle.
- R10: While `req_valid` is low, `stall`, `ext_ale`, the target selects and `rsp_valid` (after one cycle) stay 0, and both strobes stay high, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_addr | input | 16 | Data-space byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| cfg_ext_en | input | 1 | Enables the external SRAM port |
| cfg_ws | input | 2 | External wait states, 0..3 |
| sel_gpr | output | 1 | Working-register select |
| sel_io | output | 1 | I/O window select |
| sel_sram | output | 1 | On-chip SRAM select |
| tgt_off | output | 9 | Offset inside the selected internal region |
| stall | output | 1 | Core stall, high for each extra cycle |
| rsp_valid | output | 1 | Read byte from external region valid |
| rsp_data | output | 8 | Read byte from external region |
| ext_ale | output | 1 | Address latch enable for the low address byte |
| ext_ad_out | output | 8 | Multiplexed address/data out |
| ext_ad_oe | output | 1 | Output enable for ext_ad_out |
| ext_ad_in | input | 8 | Data from external SRAM |
| ext_addr_hi | output | 8 | High address byte |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
An external read completes at the same time the next request is presented. So the read response (R8) can fall in the same cycle as the decode and acceptance of the following request (R2, R4). The bench provokes this by issuing an external read with two wait states and then, at once, an I/O-window write. It does not leave an idle cycle between the two. It judges the cycle where both meet: `rsp_valid` must carry the byte the external model holds, while `sel_io`, `tgt_off` and an unstalled `req_ready` must describe the new request, with both strobes already high.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
  typedef enum logic [1:0] {
    RG_GPR  = 2'd0,
    RG_IO   = 2'd1,
    RG_SRAM = 2'd2,
    RG_EXT  = 2'd3
  } region_e;
endpackage

// File: rtl/dspace_region_map.sv
module dspace_region_map
  import dspace_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 512,
  parameter int OFF_W  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [OFF_W-1:0]  offset
);
  localparam logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(GPR_N);
  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(GPR_N + IO_N);
  localparam logic [ADDR_W-1:0] EXT_BASE  = ADDR_W'(GPR_N + IO_N + SRAM_N);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    if (addr < IO_BASE) begin
      region = RG_GPR;
      rel    = addr;
    end else if (addr < SRAM_BASE) begin
      region = RG_IO;
      rel    = addr - IO_BASE;
    end else if (addr < EXT_BASE) begin
      region = RG_SRAM;
      rel    = addr - SRAM_BASE;
    end else begin
      region = RG_EXT;
      rel    = '0;
    end
    offset = rel[OFF_W-1:0];
  end
endmodule

// File: rtl/dspace_ext_seq.sv
module dspace_ext_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_req,
  input  logic              zero_rd,
  input  logic [WS_W-1:0]   ws,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              stall,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic            busy_q;
  logic [WS_W-1:0] cnt_q;
  logic            go;
  logic            last;

  assign go    = ext_req && !busy_q;
  assign last  = busy_q && (cnt_q == '0);
  assign stall = go || (busy_q && (cnt_q != '0));
  assign ale   = go;
  assign ad_out  = go ? addr[DATA_W-1:0] : (busy_q && we ? wdata : '0);
  assign ad_oe   = go || (busy_q && we);
  assign addr_hi = (go || busy_q) ? addr[ADDR_W-1:DATA_W] : '0;
  assign rd_n  = !(busy_q && !we);
  assign wr_n  = !(busy_q && we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= ws;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (last && !we) || zero_rd;
      rsp_data  <= (last && !we) ? ad_in : '0;
    end
  end

  // Stall-length checker: counts consecutive stall cycles
  logic [WS_W:0]   run_q;
  logic [WS_W-1:0] ws_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ws_q  <= '0;
    end else begin
      run_q <= stall ? run_q + 1'b1 : '0;
      if (go) ws_q <= ws;
    end
  end

  assert_stall_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (run_q == ({1'b0, ws_q} + 1'b1)));
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_ale_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (busy_q && !ale));
endmodule

// File: rtl/dspace_dec.sv
module dspace_dec
  import dspace_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 512,
  parameter int WS_W   = 2,
  localparam int OFF_W = $clog2(SRAM_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_ext_en,
  input  logic [WS_W-1:0]   cfg_ws,
  output logic              sel_gpr,
  output logic              sel_io,
  output logic              sel_sram,
  output logic [OFF_W-1:0]  tgt_off,
  output logic              stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ext_ale,
  output logic [DATA_W-1:0] ext_ad_out,
  output logic              ext_ad_oe,
  input  logic [DATA_W-1:0] ext_ad_in,
  output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);
  region_e region;
  logic    in_ext;

  dspace_region_map #(
    .ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N), .SRAM_N(SRAM_N), .OFF_W(OFF_W)
  ) u_map (
    .addr  (req_addr),
    .region(region),
    .offset(tgt_off)
  );

  assign in_ext   = req_valid && (region == RG_EXT);
  assign sel_gpr  = req_valid && (region == RG_GPR);
  assign sel_io   = req_valid && (region == RG_IO);
  assign sel_sram = req_valid && (region == RG_SRAM);

  dspace_ext_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_req  (in_ext && cfg_ext_en),
    .zero_rd  (in_ext && !cfg_ext_en && !req_we),
    .ws       (cfg_ws),
    .addr     (req_addr),
    .we       (req_we),
    .wdata    (req_wdata),
    .ad_in    (ext_ad_in),
    .stall    (stall),
    .ale      (ext_ale),
    .ad_out   (ext_ad_out),
    .ad_oe    (ext_ad_oe),
    .addr_hi  (ext_addr_hi),
    .rd_n     (ext_rd_n),
    .wr_n     (ext_wr_n),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign req_ready = req_valid && !stall;

  assert_onehot_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_gpr, sel_io, sel_sram, stall}));
  assert_quiet_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_gpr || sel_io || sel_sram) |-> (ext_rd_n && ext_wr_n && req_ready));
  assert_disabled_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ext && !cfg_ext_en && !req_we) |=> (rsp_valid && rsp_data == '0));
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ext && !cfg_ext_en) |-> (!stall && ext_rd_n && ext_wr_n && !ext_ale));
  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we)));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!stall && !ext_ale));
endmodule

// File: tb/sim_dspace_dec.sv
module sim_dspace_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        cfg_ext_en = 1'b0;
  logic [1:0]  cfg_ws = '0;
  logic        sel_gpr, sel_io, sel_sram;
  logic [8:0]  tgt_off;
  logic        stall, rsp_valid;
  logic [7:0]  rsp_data;
  logic        ext_ale, ext_ad_oe, ext_rd_n, ext_wr_n;
  logic [7:0]  ext_ad_out, ext_ad_in, ext_addr_hi;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dspace_dec u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .cfg_ext_en(cfg_ext_en), .cfg_ws(cfg_ws),
    .sel_gpr(sel_gpr), .sel_io(sel_io), .sel_sram(sel_sram), .tgt_off(tgt_off),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ext_ale(ext_ale), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe),
    .ext_ad_in(ext_ad_in), .ext_addr_hi(ext_addr_hi),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  // External SRAM model: latches low byte on ALE, 256 bytes by low address
  logic [7:0]  xmem [256];
  logic [7:0]  shadow [256];
  logic [15:0] lat_a = '0;
  assign ext_ad_in = !ext_rd_n ? xmem[lat_a[7:0]] : 8'h00;
  always @(posedge clk) begin
    if (ext_ale) lat_a <= {ext_addr_hi, ext_ad_out};
    if (!ext_wr_n) xmem[lat_a[7:0]] <= ext_ad_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One access, released after acceptance; checks stall, strobes, bus, decode, response
  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                        input logic en, input logic [1:0] ws);
    bit   ext = (a >= 16'd608);
    int   exp_stall = (ext && en) ? 1 + ws : 0;
    int   nst = 0, nrd = 0, nwr = 0, guard = 0;
    bit   bus_ok = 1, both_low = 0;
    logic [7:0] exp_rd = (ext && en) ? shadow[a[7:0]] : 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
    cfg_ext_en = en; cfg_ws = ws;
    #1;
    if (ext && en)
      chk(ext_ale && ext_ad_oe && ext_ad_out == a[7:0] && ext_addr_hi == a[15:8],
          "R7 address phase", {ext_ale, ext_ad_oe, ext_addr_hi, ext_ad_out},
          {2'b11, a});
    while (!req_ready && guard < 20) begin
      nst += stall;
      nrd += !ext_rd_n;
      nwr += !ext_wr_n;
      if (!ext_rd_n && !ext_wr_n) both_low = 1;
      if (!ext_wr_n && !(ext_ad_oe && ext_ad_out == wd)) bus_ok = 0;
      if (!ext_rd_n && ext_ad_oe) bus_ok = 0;
      @(negedge clk); #1;
      guard++;
    end
    // acceptance cycle: last strobe cycle for external
    nrd += !ext_rd_n;
    nwr += !ext_wr_n;
    if (!ext_rd_n && !ext_wr_n) both_low = 1;
    if (!ext_wr_n && !(ext_ad_oe && ext_ad_out == wd)) bus_ok = 0;
    if (!ext_rd_n && ext_ad_oe) bus_ok = 0;
    chk(nst == exp_stall, ext ? (ws == 0 ? "R5 stall length" : "R6 stall length") : "R4 no stall",
        nst, exp_stall);
    if (ext && en) begin
      chk(!both_low && nrd == (we ? 0 : ws + 1) && nwr == (we ? ws + 1 : 0),
          "R6 strobe cycles", nrd * 16 + nwr, we ? ws + 1 : (ws + 1) * 16);
      chk(bus_ok, "R7 data phase", bus_ok, 1);
    end else
      chk(nrd == 0 && nwr == 0, ext ? "R9 no strobe when disabled" : "R4 strobes idle",
          nrd * 16 + nwr, 0);
    if (a < 16'd32)
      chk(sel_gpr && !sel_io && !sel_sram && tgt_off == a[8:0], "R1 decode",
          {sel_gpr, sel_io, sel_sram, tgt_off}, {3'b100, a[8:0]});
    else if (a < 16'd96)
      chk(!sel_gpr && sel_io && !sel_sram && tgt_off == 9'(a - 16'd32), "R2 decode",
          {sel_gpr, sel_io, sel_sram, tgt_off}, {3'b010, 9'(a - 16'd32)});
    else if (a < 16'd608)
      chk(!sel_gpr && !sel_io && sel_sram && tgt_off == 9'(a - 16'd96), "R3 decode",
          {sel_gpr, sel_io, sel_sram, tgt_off}, {3'b001, 9'(a - 16'd96)});
    else
      chk(!sel_gpr && !sel_io && !sel_sram, "R5 no internal select",
          {sel_gpr, sel_io, sel_sram}, 0);
    if (ext && en && we) shadow[a[7:0]] = wd;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (ext && !we)
      chk(rsp_valid && rsp_data == exp_rd, en ? "R8 read response" : "R9 zero read",
          {rsp_valid, rsp_data}, {1'b1, exp_rd});
    else
      chk(!rsp_valid, "R8 no response", rsp_valid, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!stall && ext_rd_n && ext_wr_n && !rsp_valid && !ext_ale &&
        !sel_gpr && !sel_io && !sel_sram, "R10 reset state",
        {stall, ext_rd_n, ext_wr_n, rsp_valid}, 4'b0110);
  endtask

  task automatic t_internal();
    access(16'd0,   1'b1, 8'h11, 1'b1, 2'd3);
    access(16'd31,  1'b0, 8'h00, 1'b1, 2'd3);
    access(16'd32,  1'b1, 8'h22, 1'b1, 2'd2);
    access(16'd95,  1'b0, 8'h00, 1'b1, 2'd1);
    access(16'd96,  1'b1, 8'h33, 1'b0, 2'd3);
    access(16'd607, 1'b0, 8'h00, 1'b1, 2'd3);
  endtask

  task automatic t_external();
    for (int w = 0; w < 4; w++) begin
      access(16'd608 + 16'(w),  1'b1, 8'hA0 + 8'(w), 1'b1, 2'(w));
      access(16'd608 + 16'(w),  1'b0, 8'h00,         1'b1, 2'(w));
      access(16'hFFFF - 16'(w), 1'b0, 8'h00,         1'b1, 2'(w));
      access(16'h1234,          1'b1, 8'h5C ^ 8'(w), 1'b1, 2'(w));
    end
    access(16'h1234, 1'b0, 8'h00, 1'b1, 2'd0);
  endtask

  task automatic t_disabled();
    access(16'd700, 1'b0, 8'h00, 1'b0, 2'd3);
    access(16'd701, 1'b1, 8'hEE, 1'b0, 2'd3);
    // R9: the disabled write must not have reached the external byte
    access(16'd701, 1'b0, 8'h00, 1'b1, 2'd0);
  endtask

  task automatic t_back2back();
    int guard = 0;
    logic [7:0] exp_rd = shadow[8'h40];
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0840; req_we = 1'b0;
    cfg_ext_en = 1'b1; cfg_ws = 2'd2;
    #1;
    while (!req_ready && guard < 20) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    req_addr = 16'd50; req_we = 1'b1; req_wdata = 8'h77;
    #1;
    chk(rsp_valid && rsp_data == exp_rd, "R8 response beside next request",
        {rsp_valid, rsp_data}, {1'b1, exp_rd});
    chk(sel_io && tgt_off == 9'd18 && req_ready && !stall && ext_rd_n && ext_wr_n,
        "R2 R4 next request decoded in same cycle", {sel_io, tgt_off, req_ready},
        {1'b1, 9'd18, 1'b1});
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(!rsp_valid, "R8 single response pulse", rsp_valid, 0);
  endtask

  task automatic t_idle();
    bit quiet = 1;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 16'h2000; req_we = 1'b0; cfg_ext_en = 1'b1; cfg_ws = 2'd3;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (stall || ext_ale || !ext_rd_n || !ext_wr_n || rsp_valid || sel_gpr || sel_io || sel_sram)
        quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R10 idle without valid", quiet, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      xmem[i]   = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_internal();
    t_external();
    t_disabled();
    t_back2back();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      vec++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule